// File: doc/BRIEF.md
# Free-Running Time Base with Compare Interrupt

The block keeps a free-running time-base counter, 56 bits wide by default, that advances on each clock cycle where a count-enable input is high. One compare frame sits beside it. Software programs a 64-bit compare value as two 32-bit halves and turns the frame on through a control register. While the frame is on, a sticky status flag sets as soon as the counter reaches or passes the compare value. It does not wait for an exact match. A level-high interrupt follows the flag unless a mask bit suppresses it.

Software reads the counter as two 32-bit words. Both words come from one counter register, so the upper word can only change in the same cycle that the lower word carries to zero. A read of the upper word, then the lower word, then the upper word again therefore settles on a consistent value. The status flag and the interrupt clear only when the enable bit is written to zero. Register access is one cycle wide: a write happens on a clock edge where the write strobe is high, and read data is the combinational decode of the present address.

Top module: `ctr_top`

## Requirements
- R1: The counter adds one on each clock edge where `cntEn` is high and keeps its value on edges where `cntEn` is low.
- R2: The counter wraps from all ones (2^CNT_W - 1) to zero.
- R3: A read at byte offset 0x8 returns counter bits 31:0. A read at 0xC returns the counter bits above bit 31, zero-extended to 32 bits. A read at any unmapped offset returns zero.
- R4: The compare value is 64 bits. Its lower word is written and read at offset 0x10020 and its upper word at offset 0x10024. A write takes effect on the next clock edge.
- R5: The control register is at offset 0x1002C. Bit 0 is enable and bit 1 is interrupt mask, both writable. Bit 2 reads back the status flag and is read-only, so writes to bit 2 have no effect. All other bits read as zero.
- R6: While enable is 1 and the compare value is less than or equal to the zero-extended counter, status is 1 one cycle later. This holds for equality and for less-than, including the case where enable is turned on after the counter has already passed the compare value. Once set, status stays 1 while enable stays 1.
- R7: Writing enable to 0 clears status and drops `irq` on the same edge. Status never sets while enable is 0.
- R8: `irq` is high exactly when status, enable and NOT mask are all 1. Status still sets while mask is 1.
- R9: Reset clears the counter, the compare value, enable, mask and status, and `irq` is low.
- R10: The counter's upper word changes only on an edge where the lower word becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Count-enable pulse for the counter |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte offset for read and write |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| irq | output | 1 | Level interrupt, active high |

## Verification
Several properties are checked on every cycle: the counter's step-or-hold behaviour and its wrap, the upper word moving only when the lower word carries, status following any enabled compare hit one cycle later and staying sticky, status being absent whenever enable is low, and the mask always holding `irq` low. Only the bench scenarios can show the register map as software sees it. That includes the offsets, the read-only status bit that ignores writes, and the zero returned at unmapped offsets. The scenarios also show the equality and less-than cases reached through real counting, the upper compare word keeping the frame quiet, and the order in which enable, mask and status interact through writes.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned OFF_CNT_LO = 32'h0000_0008;
  localparam int unsigned OFF_CNT_HI = 32'h0000_000C;
  localparam int unsigned OFF_CMP_LO = 32'h0001_0020;
  localparam int unsigned OFF_CMP_HI = 32'h0001_0024;
  localparam int unsigned OFF_CTRL   = 32'h0001_002C;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_MASK = 1;
  localparam int unsigned BIT_STAT = 2;

  typedef struct packed {
    logic        cmpLoWr;
    logic        cmpHiWr;
    logic        ctrlWr;
    logic [31:0] wdata;
  } strobe_t;
endpackage

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import ctr_pkg::*;
#(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cnt,
  output logic [63:0]      cmpVal,
  output logic             en,
  output logic             mask,
  output logic             status,
  output logic             irq
);
  logic cmpHit;
  assign cmpHit = (cmpVal <= 64'(cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cntEn) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmpVal <= '0;
    else begin
      if (strb.cmpLoWr) cmpVal[31:0]  <= strb.wdata;
      if (strb.cmpHiWr) cmpVal[63:32] <= strb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      mask   <= 1'b0;
      status <= 1'b0;
    end else begin
      if (strb.ctrlWr) begin
        en   <= strb.wdata[BIT_EN];
        mask <= strb.wdata[BIT_MASK];
      end
      if (strb.ctrlWr && !strb.wdata[BIT_EN]) status <= 1'b0;
      else if (en && cmpHit)                  status <= 1'b1;
      else if (!en)                           status <= 1'b0;
    end
  end

  assign irq = status & en & ~mask;
endmodule

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
#(
  parameter int CNT_W  = 56,
  parameter int ADDR_W = 17
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [63:0]       cmpVal,
  input  logic              en,
  input  logic              mask,
  input  logic              status,
  output strobe_t           strb,
  output logic [31:0]       busRdata
);
  logic [63:0] cntWide;
  logic hitCntLo, hitCntHi, hitCmpLo, hitCmpHi, hitCtrl;

  assign cntWide  = 64'(cnt);
  assign hitCntLo = (busAddr == ADDR_W'(OFF_CNT_LO));
  assign hitCntHi = (busAddr == ADDR_W'(OFF_CNT_HI));
  assign hitCmpLo = (busAddr == ADDR_W'(OFF_CMP_LO));
  assign hitCmpHi = (busAddr == ADDR_W'(OFF_CMP_HI));
  assign hitCtrl  = (busAddr == ADDR_W'(OFF_CTRL));

  always_comb begin
    strb.cmpLoWr = busWe & hitCmpLo;
    strb.cmpHiWr = busWe & hitCmpHi;
    strb.ctrlWr  = busWe & hitCtrl;
    strb.wdata   = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (hitCntLo)      busRdata = cntWide[31:0];
    else if (hitCntHi) busRdata = cntWide[63:32];
    else if (hitCmpLo) busRdata = cmpVal[31:0];
    else if (hitCmpHi) busRdata = cmpVal[63:32];
    else if (hitCtrl) begin
      busRdata[BIT_EN]   = en;
      busRdata[BIT_MASK] = mask;
      busRdata[BIT_STAT] = status;
    end
  end
endmodule

// File: rtl/ctr_top.sv
module ctr_top
  import ctr_pkg::*;
#(
  parameter int CNT_W  = 56,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);
  strobe_t          strb;
  logic [CNT_W-1:0] cnt;
  logic [63:0]      cmpVal;
  logic             en, mask, status;

  ctr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .cnt(cnt), .cmpVal(cmpVal), .en(en), .mask(mask), .status(status),
    .strb(strb), .busRdata(busRdata)
  );

  ctr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .strb(strb),
    .cnt(cnt), .cmpVal(cmpVal), .en(en), .mask(mask),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/ctr_chk.sv
module ctr_chk #(
  parameter int CNT_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cntEn,
  input logic [CNT_W-1:0] cnt,
  input logic [63:0]      cmpVal,
  input logic             en,
  input logic             mask,
  input logic             status,
  input logic             irq
);
  logic [63:0] cntWide;
  assign cntWide = 64'(cnt);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cntEn |=> cnt == $past(cnt) + 1'b1);
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cntEn |=> $stable(cnt));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEn && (&cnt)) |=> cnt == '0);
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmpVal <= cntWide) |=> (status || !en));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status && en) |=> (status || !en));
  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !status);
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && en));
  p_hi_atomic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cntWide[63:32] != $past(cntWide[63:32])) |-> cntWide[31:0] == 32'd0);
endmodule

bind ctr_top ctr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .cnt(cnt), .cmpVal(cmpVal),
  .en(en), .mask(mask), .status(status), .irq(irq)
);

// File: tb/ctr_top_tb_top.sv
module ctr_top_tb_top;
  localparam int ADDR_W = 17;
  localparam int WRAP_W = 10;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              isIrq;
    logic [31:0]       exp;
    string             req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cntEn = 1'b0;
  logic busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq;

  logic wCntEn = 1'b0;
  logic [ADDR_W-1:0] wAddr = '0;
  logic [31:0] wRdata;
  logic wIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  ctr_top #(.CNT_W(56), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  ctr_top #(.CNT_W(WRAP_W), .ADDR_W(ADDR_W)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .cntEn(wCntEn), .busWe(1'b0), .busAddr(wAddr),
    .busWdata(32'd0), .busRdata(wRdata), .irq(wIrq)
  );

  task automatic judge(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares them with the design's outputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        busAddr = it.addr;
        #0.5;
        if (it.isIrq) judge({31'd0, irq}, it.exp, it.req);
        else          judge(busRdata, it.exp, it.req);
      end
    end
  end

  task automatic expectRd(input int unsigned addr, input logic [31:0] exp, input string req);
    item_t it;
    it.addr = ADDR_W'(addr); it.isIrq = 1'b0; it.exp = exp; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic expectIrq(input logic v, input string req);
    item_t it;
    it.addr = '0; it.isIrq = 1'b1; it.exp = {31'd0, v}; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic busWr(input int unsigned addr, input logic [31:0] data);
    @(negedge clk);
    busWe = 1'b1; busAddr = ADDR_W'(addr); busWdata = data;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic runCnt(input int n);
    @(negedge clk);
    cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    expectRd(32'h8, 32'd0, "R9");
    expectRd(32'h10020, 32'd0, "R9");
    expectRd(32'h10024, 32'd0, "R9");
    expectRd(32'h1002C, 32'd0, "R9");
    expectIrq(1'b0, "R9");
    // R1 counting and holding
    runCnt(25);
    expectRd(32'h8, 32'd25, "R1");
    repeat (5) @(negedge clk);
    expectRd(32'h8, 32'd25, "R1");
    expectRd(32'hC, 32'd0, "R10");
    // R3 unmapped offsets
    expectRd(32'h4, 32'd0, "R3");
    expectRd(32'h10028, 32'd0, "R3");
    // R4 compare halves
    busWr(32'h10020, 32'h30);
    busWr(32'h10024, 32'h1);
    expectRd(32'h10020, 32'h30, "R4");
    expectRd(32'h10024, 32'h1, "R4");
    // R5 control bits; bit 2 write ignored; upper compare word keeps frame quiet (R6)
    busWr(32'h1002C, 32'h7);
    expectRd(32'h1002C, 32'h3, "R5");
    expectIrq(1'b0, "R6");
    busWr(32'h10024, 32'h0);
    runCnt(22);
    expectRd(32'h1002C, 32'h3, "R6");
    runCnt(1);
    // R6 equality sets status, R8 masked: status set, irq low
    expectRd(32'h1002C, 32'h7, "R6");
    expectIrq(1'b0, "R8");
    // R8 unmask; bit-2 write of 0 ignored (R5)
    busWr(32'h1002C, 32'h1);
    expectRd(32'h1002C, 32'h5, "R5");
    expectIrq(1'b1, "R8");
    // R7 disable clears
    busWr(32'h1002C, 32'h0);
    expectRd(32'h1002C, 32'h0, "R7");
    expectIrq(1'b0, "R7");
    runCnt(3);
    expectRd(32'h1002C, 32'h0, "R7");
    // R6 enable after passing: less-than case
    busWr(32'h1002C, 32'h1);
    expectRd(32'h1002C, 32'h5, "R6");
    expectIrq(1'b1, "R6");
    busWr(32'h1002C, 32'h0);
    expectIrq(1'b0, "R7");
    // R2 wrap on the narrow instance
    @(negedge clk);
    wCntEn = 1'b1;
    repeat ((1 << WRAP_W) + 6) @(negedge clk);
    wCntEn = 1'b0;
    wAddr = ADDR_W'(32'h8);
    #0.5 judge(wRdata, 32'd6, "R2");
    wAddr = ADDR_W'(32'hC);
    #0.5 judge(wRdata, 32'd0, "R3");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule